// File: doc/BRIEF.md
# Online Windowed Memory Self-Test Engine

This block sits between functional logic and a single-port synchronous RAM. It tests the RAM while the RAM stays in service. It does this by running many short bursts rather than one long test. Each burst covers a window of `WIN` consecutive words. A burst first copies the window into a private buffer. It then writes a pattern and reads it back, writes the inverted pattern and reads it back, and finally writes the buffered words back. The window's functional contents are therefore the same after the burst as before it.

The engine only claims the memory in a cycle where it is enabled, no functional request is present and no abort is being asked for. Once a burst has begun it always runs to its end. Functional requests that arrive during a burst are held off with a ready signal. A window index steps after every burst and reports progress. When the last window completes, a one-cycle done pulse is raised, and the engine either stops or starts a new pass. The first read that does not match latches a sticky fail flag and the failing address.

The RAM returns read data one cycle after the address is presented. A write at address A replaces the word at A at the clock edge.

Top module: `mbist_burst`

## Requirements
- R1: After reset, `fn_ready`=1, `st_running`=0, `st_done`=0, `st_fail`=0 and `st_window`=0, and `mem_en` is 0 while `fn_req` is 0.
- R2: A burst starts only in a cycle where the engine is running, `fn_req`=0 and `ctl_abort`=0. That first cycle still shows `fn_ready`=1. `fn_ready` then stays 0 for exactly 6*WIN-1 further cycles (23 by default), and `mem_en` is 1 in every one of them.
- R3: A burst on window w touches the addresses w*WIN..w*WIN+WIN-1, one operation per cycle in ascending order, in six phases: read all, write PATTERN (default 0x55), read all, write ~PATTERN (0xAA), read all, write back the words read in the first phase.
- R4: When a pass ends, every RAM word holds the value it held before the pass. This includes a word whose stored bits are faulty.
- R5: A functional request raised during a burst sees `fn_ready`=0 until the burst's final write-back cycle. It is served, with its address and write enable on the memory port, in the cycle immediately after that write-back.
- R6: `st_window` advances by one when each burst ends. A start from the stopped state sets it to 0.
- R7: When the burst on the last window ends, `st_window` wraps to 0 and `st_done` is 1 for exactly one cycle. With `ctl_loop`=0 the engine stops (`st_running`=0) at that same edge. With `ctl_loop`=1 it keeps running and the next pass begins.
- R8: The first read-compare mismatch sets `st_fail` and stores its address in `st_fail_addr`. Both hold through later mismatches and passes. Only a start from the stopped state clears them.
- R9: An abort raised during a burst lets that burst finish all its cycles and then stops the engine. An abort raised between bursts stops it at the next edge with no burst started.
- R10: A start pulse while the engine is running has no effect: `st_window` is not reset and running continues.
- R11: When no burst owns the memory, the memory port copies `fn_req`, `fn_we`, `fn_addr` and `fn_wdata`, and `fn_rdata` returns the RAM read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Start pulse; honoured only when stopped |
| ctl_abort | input | 1 | Abort pulse; takes effect at a burst boundary |
| ctl_loop | input | 1 | 1 = begin a new pass after the last window |
| fn_req | input | 1 | Functional access request |
| fn_we | input | 1 | Functional write enable |
| fn_addr | input | AW | Functional address |
| fn_wdata | input | DW | Functional write data |
| fn_ready | output | 1 | 0 while a burst holds the memory |
| fn_rdata | output | DW | Read data to functional side, one cycle after request |
| mem_en | output | 1 | RAM enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data (one-cycle latency) |
| st_running | output | 1 | Engine enabled |
| st_window | output | AW-log2(WIN) | Index of next window to test |
| st_done | output | 1 | One-cycle pulse at end of a pass |
| st_fail | output | 1 | Sticky mismatch flag |
| st_fail_addr | output | AW | Address of first mismatch |

## Verification
Every cycle, the bound checker confirms several things. A burst begins only when the engine may claim the memory. A burst holds the memory for exactly its fixed length. An idle port passes functional traffic straight through. The window index only steps or wraps, and only at burst boundaries. The done flag is a single-cycle pulse, the fail flag and address are sticky, and the engine stops only between bursts. Other behaviour can only be shown by the bench's scenarios: the exact per-cycle address and data order within a burst, that contents survive whole passes (with stuck-bit faults injected into the bench's RAM model), which mismatch address is recorded when two faults exist, and the exact cycle in which a stalled request is served.

// File: rtl/mbist_burst_pkg.sv
package mbist_burst_pkg;

   // Phase order inside one burst; the sequencer steps through them in this order.
   typedef enum logic [2:0] {
      PH_SAVE    = 3'd0,
      PH_WR_P    = 3'd1,
      PH_RD_P    = 3'd2,
      PH_WR_N    = 3'd3,
      PH_RD_N    = 3'd4,
      PH_RESTORE = 3'd5
   } phase_e;

   localparam int unsigned NUM_PHASES = 6;

   function automatic logic phase_reads(phase_e p);
      return (p == PH_SAVE) || (p == PH_RD_P) || (p == PH_RD_N);
   endfunction

   function automatic logic phase_compares(phase_e p);
      return (p == PH_RD_P) || (p == PH_RD_N);
   endfunction

endpackage

// File: rtl/mbist_burst_seq.sv
module mbist_burst_seq
   import mbist_burst_pkg::*;
#(
   parameter int unsigned AW        = 6,
   parameter int unsigned DW        = 8,
   parameter int unsigned WIN       = 4,
   parameter logic [DW-1:0] PATTERN = DW'('h55),
   parameter bit          ADDR_SEED = 1'b0,
   localparam int unsigned LW       = $clog2(WIN),
   localparam int unsigned WW       = AW - LW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [WW-1:0] win_idx,
   input  logic [DW-1:0] mem_rdata,
   output logic          in_burst,
   output logic          burst_end,
   output logic          b_en,
   output logic          b_we,
   output logic [AW-1:0] b_addr,
   output logic [DW-1:0] b_wdata,
   output logic          miscmp,
   output logic [AW-1:0] miscmp_addr
);

   localparam int unsigned BURST_LEN = NUM_PHASES * WIN;
   localparam int unsigned CW        = $clog2(BURST_LEN);
   localparam logic [CW-1:0] LAST    = CW'(BURST_LEN - 1);

   logic          in_burst_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] step;
   logic [CW-1:0] ph_raw;
   phase_e        phase;
   logic [LW-1:0] idx;
   logic          active;

   // read-return pipeline, one stage to match RAM latency
   logic          rd_v_q;
   phase_e        rd_ph_q;
   logic [LW-1:0] rd_idx_q;
   logic [AW-1:0] rd_addr_q;

   logic [DW-1:0] save_q [WIN];
   logic [DW-1:0] pat_w;
   logic [DW-1:0] pat_r;
   logic [DW-1:0] expect_w;

   // step counter: step 0 is the grant cycle, in_burst covers steps 1..LAST
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_burst_q <= 1'b0;
         cnt_q      <= '0;
      end else if (go && !in_burst_q) begin
         in_burst_q <= 1'b1;
         cnt_q      <= CW'(1);
      end else if (in_burst_q) begin
         if (cnt_q == LAST) begin
            in_burst_q <= 1'b0;
            cnt_q      <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign step      = in_burst_q ? cnt_q : '0;
   assign ph_raw    = step >> LW;
   assign phase     = phase_e'(ph_raw[2:0]);
   assign idx       = step[LW-1:0];
   assign active    = go | in_burst_q;
   assign in_burst  = in_burst_q;
   assign burst_end = in_burst_q && (cnt_q == LAST);

   assign b_en   = active;
   assign b_we   = active && (phase inside {PH_WR_P, PH_WR_N, PH_RESTORE});
   assign b_addr = {win_idx, idx};

   generate
      if (ADDR_SEED) begin : g_seeded
         assign pat_w = PATTERN ^ DW'(b_addr);
         assign pat_r = PATTERN ^ DW'(rd_addr_q);
      end else begin : g_fixed
         assign pat_w = PATTERN;
         assign pat_r = PATTERN;
      end
   endgenerate

   always_comb begin
      case (phase)
         PH_WR_P:    b_wdata = pat_w;
         PH_WR_N:    b_wdata = ~pat_w;
         PH_RESTORE: b_wdata = save_q[idx];
         default:    b_wdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_v_q    <= 1'b0;
         rd_ph_q   <= PH_SAVE;
         rd_idx_q  <= '0;
         rd_addr_q <= '0;
      end else begin
         rd_v_q    <= active && phase_reads(phase);
         rd_ph_q   <= phase;
         rd_idx_q  <= idx;
         rd_addr_q <= b_addr;
      end
   end

   // save buffer, one register per window word
   generate
      for (genvar g = 0; g < WIN; g++) begin : g_save
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               save_q[g] <= '0;
            end else if (rd_v_q && (rd_ph_q == PH_SAVE) && (rd_idx_q == LW'(g))) begin
               save_q[g] <= mem_rdata;
            end
         end
      end
   endgenerate

   assign expect_w    = (rd_ph_q == PH_RD_N) ? ~pat_r : pat_r;
   assign miscmp      = rd_v_q && phase_compares(rd_ph_q) && (mem_rdata != expect_w);
   assign miscmp_addr = rd_addr_q;

endmodule

// File: rtl/mbist_burst_ctrl.sv
module mbist_burst_ctrl #(
   parameter int unsigned AW = 6,
   parameter int unsigned WW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_start,
   input  logic          ctl_abort,
   input  logic          ctl_loop,
   input  logic          in_burst,
   input  logic          burst_end,
   input  logic          miscmp,
   input  logic [AW-1:0] miscmp_addr,
   output logic          may_start,
   output logic          running,
   output logic [WW-1:0] win_idx,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr
);

   logic          running_q;
   logic          abort_pend_q;
   logic [WW-1:0] win_q;
   logic          done_q;
   logic          fail_q;
   logic [AW-1:0] fail_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q    <= 1'b0;
         abort_pend_q <= 1'b0;
         win_q        <= '0;
         done_q       <= 1'b0;
         fail_q       <= 1'b0;
         fail_addr_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (ctl_start && !running_q) begin
            running_q    <= 1'b1;
            abort_pend_q <= 1'b0;
            win_q        <= '0;
            fail_q       <= 1'b0;
            fail_addr_q  <= '0;
         end else begin
            if (burst_end) begin
               win_q <= win_q + 1'b1;
               if (win_q == '1) begin
                  done_q <= 1'b1;
                  if (!ctl_loop) running_q <= 1'b0;
               end
               if (abort_pend_q || ctl_abort) begin
                  running_q    <= 1'b0;
                  abort_pend_q <= 1'b0;
               end
            end else if (ctl_abort && running_q) begin
               if (in_burst) abort_pend_q <= 1'b1;
               else          running_q    <= 1'b0;
            end
            if (miscmp && !fail_q) begin
               fail_q      <= 1'b1;
               fail_addr_q <= miscmp_addr;
            end
         end
      end
   end

   assign may_start = running_q && !ctl_abort && !abort_pend_q;
   assign running   = running_q;
   assign win_idx   = win_q;
   assign done      = done_q;
   assign fail      = fail_q;
   assign fail_addr = fail_addr_q;

endmodule

// File: rtl/mbist_burst_mux.sv
module mbist_burst_mux #(
   parameter int unsigned AW        = 6,
   parameter int unsigned DW        = 8,
   parameter bit          GATE_IDLE = 1'b1
)(
   input  logic          fn_req,
   input  logic          fn_we,
   input  logic [AW-1:0] fn_addr,
   input  logic [DW-1:0] fn_wdata,
   input  logic          may_start,
   input  logic          in_burst,
   input  logic          b_en,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic          go,
   output logic          fn_ready,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);

   logic sel_bist;

   // functional side wins any cycle it asks; a burst never starts under it
   assign go       = may_start && !fn_req && !in_burst;
   assign sel_bist = go || in_burst;
   assign fn_ready = !in_burst;
   assign mem_en   = sel_bist ? b_en : fn_req;
   assign mem_we   = sel_bist ? b_we : (fn_req && fn_we);

   generate
      if (GATE_IDLE) begin : g_gated
         assign mem_addr  = sel_bist ? b_addr  : (fn_req ? fn_addr  : '0);
         assign mem_wdata = sel_bist ? b_wdata : (fn_req ? fn_wdata : '0);
      end else begin : g_open
         assign mem_addr  = sel_bist ? b_addr  : fn_addr;
         assign mem_wdata = sel_bist ? b_wdata : fn_wdata;
      end
   endgenerate

endmodule

// File: rtl/mbist_burst.sv
module mbist_burst
   import mbist_burst_pkg::*;
#(
   parameter int unsigned AW        = 6,
   parameter int unsigned DW        = 8,
   parameter int unsigned WIN       = 4,
   parameter logic [DW-1:0] PATTERN = DW'('h55),
   parameter bit          ADDR_SEED = 1'b0,
   parameter bit          GATE_IDLE = 1'b1,
   parameter int unsigned MAX_BURST = 28,
   localparam int unsigned LW       = $clog2(WIN),
   localparam int unsigned WW       = AW - LW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_start,
   input  logic          ctl_abort,
   input  logic          ctl_loop,
   input  logic          fn_req,
   input  logic          fn_we,
   input  logic [AW-1:0] fn_addr,
   input  logic [DW-1:0] fn_wdata,
   output logic          fn_ready,
   output logic [DW-1:0] fn_rdata,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          st_running,
   output logic [WW-1:0] st_window,
   output logic          st_done,
   output logic          st_fail,
   output logic [AW-1:0] st_fail_addr
);

   localparam int unsigned BURST_LEN = NUM_PHASES * WIN;

   generate
      if (WIN < 2 || (WIN & (WIN - 1)) != 0) begin : g_bad_win
         $error("WIN must be a power of two of at least 2");
      end
      if (LW >= AW) begin : g_bad_aw
         $error("AW must leave at least one window index bit");
      end
      if (BURST_LEN > MAX_BURST) begin : g_bad_len
         $error("burst length exceeds MAX_BURST");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
   endgenerate

   logic          go;
   logic          may_start;
   logic          in_burst;
   logic          burst_end;
   logic          b_en;
   logic          b_we;
   logic [AW-1:0] b_addr;
   logic [DW-1:0] b_wdata;
   logic          miscmp;
   logic [AW-1:0] miscmp_addr;

   mbist_burst_mux #(.AW(AW), .DW(DW), .GATE_IDLE(GATE_IDLE)) u_mux (
      .fn_req    (fn_req),
      .fn_we     (fn_we),
      .fn_addr   (fn_addr),
      .fn_wdata  (fn_wdata),
      .may_start (may_start),
      .in_burst  (in_burst),
      .b_en      (b_en),
      .b_we      (b_we),
      .b_addr    (b_addr),
      .b_wdata   (b_wdata),
      .go        (go),
      .fn_ready  (fn_ready),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   mbist_burst_seq #(
      .AW(AW), .DW(DW), .WIN(WIN), .PATTERN(PATTERN), .ADDR_SEED(ADDR_SEED)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .win_idx     (st_window),
      .mem_rdata   (mem_rdata),
      .in_burst    (in_burst),
      .burst_end   (burst_end),
      .b_en        (b_en),
      .b_we        (b_we),
      .b_addr      (b_addr),
      .b_wdata     (b_wdata),
      .miscmp      (miscmp),
      .miscmp_addr (miscmp_addr)
   );

   mbist_burst_ctrl #(.AW(AW), .WW(WW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_start   (ctl_start),
      .ctl_abort   (ctl_abort),
      .ctl_loop    (ctl_loop),
      .in_burst    (in_burst),
      .burst_end   (burst_end),
      .miscmp      (miscmp),
      .miscmp_addr (miscmp_addr),
      .may_start   (may_start),
      .running     (st_running),
      .win_idx     (st_window),
      .done        (st_done),
      .fail        (st_fail),
      .fail_addr   (st_fail_addr)
   );

   assign fn_rdata = mem_rdata;

endmodule

// File: rtl/mbist_burst_chk.sv
module mbist_burst_chk #(
   parameter int unsigned AW        = 6,
   parameter int unsigned WW        = 4,
   parameter int unsigned BURST_LEN = 24
)(
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_start,
   input logic          ctl_abort,
   input logic          fn_req,
   input logic          fn_we,
   input logic [AW-1:0] fn_addr,
   input logic          fn_ready,
   input logic          mem_en,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          st_running,
   input logic [WW-1:0] st_window,
   input logic          st_done,
   input logic          st_fail,
   input logic [AW-1:0] st_fail_addr
);

   localparam int unsigned KW = $clog2(BURST_LEN) + 1;

   logic [KW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         low_cnt <= '0;
      else if (!fn_ready) low_cnt <= low_cnt + 1'b1;
      else                low_cnt <= '0;
   end

   AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !fn_ready |-> mem_en);                                                  // R2
   AST_GRANT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fn_ready) |-> $past(st_running && !fn_req && !ctl_abort));       // R2
   AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fn_ready) |-> (low_cnt == KW'(BURST_LEN - 1)));                   // R2
   AST_FN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_ready && fn_req) |-> (mem_en && mem_we == fn_we && mem_addr == fn_addr)); // R11
   AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_window != $past(st_window)) |->
         (st_window == WW'($past(st_window) + 1'b1) || st_window == '0));     // R6
   AST_WIN_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_window != $past(st_window)) |-> fn_ready);                          // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |=> !st_done);                                                  // R7
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fail && !ctl_start) |=> st_fail);                                   // R8
   AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fail && !ctl_start) |=> $stable(st_fail_addr));                     // R8
   AST_STOP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_running) |-> fn_ready);                                        // R9

endmodule

bind mbist_burst mbist_burst_chk #(.AW(AW), .WW(WW), .BURST_LEN(BURST_LEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_start    (ctl_start),
   .ctl_abort    (ctl_abort),
   .fn_req       (fn_req),
   .fn_we        (fn_we),
   .fn_addr      (fn_addr),
   .fn_ready     (fn_ready),
   .mem_en       (mem_en),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .st_running   (st_running),
   .st_window    (st_window),
   .st_done      (st_done),
   .st_fail      (st_fail),
   .st_fail_addr (st_fail_addr)
);

// File: tb/mbist_burst_bench.sv
`timescale 1ns/1ps
module mbist_burst_bench;

   localparam int AW = 6;
   localparam int DW = 8;
   localparam int WIN = 4;
   localparam int WORDS = 1 << AW;
   localparam int BLEN = 6 * WIN;

   typedef struct packed {
      logic       a_en;
      logic [5:0] a_addr;
      logic [7:0] a_mask;
      logic       b_en;
      logic [5:0] b_addr;
      logic [7:0] b_mask;
      logic       exp_fail;
      logic [5:0] exp_addr;
      logic [7:0] seed;
   } vec_t;

   // stuck-at-1 storage faults per vector and the expected first-fail address
   localparam vec_t VECS [5] = '{
      '{1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  8'h00, 1'b0, 6'd0,  8'h13},
      '{1'b1, 6'd5,  8'h01, 1'b0, 6'd0,  8'h00, 1'b1, 6'd5,  8'h27},
      '{1'b1, 6'd63, 8'h02, 1'b0, 6'd0,  8'h00, 1'b1, 6'd63, 8'h3C},
      '{1'b1, 6'd0,  8'h80, 1'b0, 6'd0,  8'h00, 1'b1, 6'd0,  8'h91},
      '{1'b1, 6'd9,  8'h01, 1'b1, 6'd40, 8'h40, 1'b1, 6'd9,  8'hE5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_start = 1'b0, ctl_abort = 1'b0, ctl_loop = 1'b0;
   logic fn_req = 1'b0, fn_we = 1'b0;
   logic [AW-1:0] fn_addr = '0;
   logic [DW-1:0] fn_wdata = '0;
   logic fn_ready, mem_en, mem_we, st_running, st_done, st_fail;
   logic [DW-1:0] fn_rdata, mem_wdata;
   logic [AW-1:0] mem_addr, st_fail_addr;
   logic [AW-3:0] st_window;
   logic [DW-1:0] rdq = '0;

   logic       fa_en = 1'b0, fb_en = 1'b0;
   logic [5:0] fa_addr = '0, fb_addr = '0;
   logic [7:0] fa_mask = '0, fb_mask = '0;
   logic [7:0] img [WORDS];

   int unsigned checks = 0;
   int unsigned errors = 0;

   always #4 clk = ~clk;

   mbist_burst u_mbist_burst (
      .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_abort(ctl_abort),
      .ctl_loop(ctl_loop), .fn_req(fn_req), .fn_we(fn_we), .fn_addr(fn_addr),
      .fn_wdata(fn_wdata), .fn_ready(fn_ready), .fn_rdata(fn_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(rdq), .st_running(st_running), .st_window(st_window),
      .st_done(st_done), .st_fail(st_fail), .st_fail_addr(st_fail_addr)
   );

   function automatic logic [7:0] fmask(input logic [5:0] a);
      return ((fa_en && a == fa_addr) ? fa_mask : 8'h00) |
             ((fb_en && a == fb_addr) ? fb_mask : 8'h00);
   endfunction

   // RAM model with stuck-at-1 storage bits
   logic [7:0] ram [WORDS];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= mem_wdata | fmask(mem_addr);
         rdq <= ram[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fn_write(input logic [5:0] a, input logic [7:0] d);
      fn_req = 1'b1; fn_we = 1'b1; fn_addr = a; fn_wdata = d;
      @(negedge clk);
      fn_req = 1'b0; fn_we = 1'b0;
   endtask

   task automatic fn_read(input logic [5:0] a, output logic [7:0] d);
      fn_req = 1'b1; fn_we = 1'b0; fn_addr = a;
      @(negedge clk);
      d = fn_rdata;
      fn_req = 1'b0;
   endtask

   task automatic fill(input logic [7:0] seed);
      for (int a = 0; a < WORDS; a++) begin
         img[a] = (seed ^ 8'(a * 7)) | fmask(6'(a));
         fn_write(6'(a), seed ^ 8'(a * 7));
      end
   endtask

   task automatic verify_image(input string what);
      int bad;
      logic [7:0] d;
      bad = 0;
      for (int a = 0; a < WORDS; a++) begin
         fn_read(6'(a), d);
         if (d !== img[a]) bad++;
      end
      chk(bad == 0, "R4", what, 32'(bad), 32'd0);
   endtask

   task automatic pulse_start();
      ctl_start = 1'b1;
      @(negedge clk);
      ctl_start = 1'b0;
   endtask

   task automatic stop_engine();
      ctl_abort = 1'b1;
      @(negedge clk);
      ctl_abort = 1'b0;
      repeat (BLEN + 2) @(negedge clk);
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int n = 0; n < 4 * WORDS * 6 && !seen; n++) begin
         @(negedge clk);
         if (st_done) seen = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit seen;
      logic [7:0] d;
      int waits;
      logic [15:0] act, exp;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(fn_ready == 1'b1, "R1", "fn_ready", 32'(fn_ready), 32'd1);
      chk({st_running, st_done, st_fail} == 3'b000, "R1", "status", 32'({st_running, st_done, st_fail}), 32'd0);
      chk(st_window == '0, "R1", "window", 32'(st_window), 32'd0);
      chk(mem_en == 1'b0, "R1", "mem_en idle", 32'(mem_en), 32'd0);

      // R11 pass-through
      fn_req = 1'b1; fn_we = 1'b1; fn_addr = 6'd12; fn_wdata = 8'hA5;
      #1;
      chk({mem_en, mem_we, mem_addr, mem_wdata} == {1'b1, 1'b1, 6'd12, 8'hA5}, "R11", "write path",
          32'({mem_en, mem_we, mem_addr, mem_wdata}), 32'({1'b1, 1'b1, 6'd12, 8'hA5}));
      @(negedge clk);
      fn_req = 1'b0; fn_we = 1'b0;
      fn_read(6'd12, d);
      chk(d == 8'hA5, "R11", "read data", 32'(d), 32'hA5);

      // table of fault vectors, one full pass each
      foreach (VECS[i]) begin
         fa_en = VECS[i].a_en; fa_addr = VECS[i].a_addr; fa_mask = VECS[i].a_mask;
         fb_en = VECS[i].b_en; fb_addr = VECS[i].b_addr; fb_mask = VECS[i].b_mask;
         fill(VECS[i].seed);
         ctl_loop = 1'b0;
         pulse_start();
         wait_done(seen);
         chk(seen, "R7", "done seen", 32'(seen), 32'd1);
         chk(st_running == 1'b0, "R7", "stopped after pass", 32'(st_running), 32'd0);
         chk(st_fail == VECS[i].exp_fail, "R8", "fail flag", 32'(st_fail), 32'(VECS[i].exp_fail));
         if (VECS[i].exp_fail)
            chk(st_fail_addr == VECS[i].exp_addr, "R8", "first fail addr",
                32'(st_fail_addr), 32'(VECS[i].exp_addr));
         verify_image("contents after pass");
      end

      // R8 start from stopped clears fail
      fa_en = 1'b0; fb_en = 1'b0;
      pulse_start();
      chk(st_fail == 1'b0 && st_running == 1'b1, "R8", "start clears fail",
          32'({st_fail, st_running}), 32'b01);
      stop_engine();

      // R3 exact burst trace on window 0
      fill(8'h5A);
      ctl_start = 1'b1;
      @(negedge clk);
      ctl_start = 1'b0;
      for (int k = 0; k < BLEN; k++) begin
         int ph, a;
         logic w;
         logic [7:0] wd;
         if (k > 0) @(negedge clk);
         ph = k / WIN;
         a  = k % WIN;
         w  = (ph == 1) || (ph == 3) || (ph == 5);
         wd = (ph == 1) ? 8'h55 : (ph == 3) ? 8'hAA : (ph == 5) ? img[a] : 8'h00;
         exp = {1'b1, w, 6'(a), wd};
         act = {mem_en, mem_we, mem_addr, mem_we ? mem_wdata : 8'h00};
         chk(act == exp, "R3", "burst step", 32'(act), 32'(exp));
         if (k > 0) chk(fn_ready == 1'b0, "R2", "ready low in burst", 32'(fn_ready), 32'd0);
      end

      // R6 next burst on window 1, R9 abort mid-burst
      @(negedge clk);
      chk(st_window == 4'd1, "R6", "window after burst", 32'(st_window), 32'd1);
      chk(mem_en && mem_addr == 6'd4, "R2", "back-to-back start", 32'(mem_addr), 32'd4);
      repeat (3) @(negedge clk);
      ctl_abort = 1'b1;
      @(negedge clk);
      ctl_abort = 1'b0;
      for (int k = 4; k < BLEN; k++) begin
         if (k > 4) @(negedge clk);
         chk(mem_en && !fn_ready, "R9", "burst completes after abort", 32'({mem_en, fn_ready}), 32'b10);
      end
      @(negedge clk);
      chk(st_running == 1'b0 && fn_ready && !mem_en, "R9", "stopped at boundary",
          32'({st_running, fn_ready, mem_en}), 32'b010);
      chk(st_window == 4'd2, "R6", "window after abort", 32'(st_window), 32'd2);
      verify_image("contents after abort");

      // R10 start while running
      pulse_start();
      chk(st_window == '0, "R6", "start resets window", 32'(st_window), 32'd0);
      repeat (60) @(negedge clk);
      pulse_start();
      chk(st_running && st_window != '0, "R10", "start ignored while running",
          32'({st_running, st_window}), 32'h1F);
      stop_engine();

      // R5 stalled request served right after restore
      ctl_start = 1'b1;
      @(negedge clk);
      ctl_start = 1'b0;
      @(negedge clk);
      fn_req = 1'b1; fn_we = 1'b0; fn_addr = 6'd7;
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!fn_ready && waits < 100);
      chk(waits == BLEN - 1, "R5", "stall cycles", 32'(waits), 32'(BLEN - 1));
      chk(mem_en && !mem_we && mem_addr == 6'd7, "R5", "served on port",
          32'({mem_en, mem_we, mem_addr}), 32'({1'b1, 1'b0, 6'd7}));
      waits = 0;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         if (!fn_ready) waits++;
      end
      chk(waits == 0, "R2", "no burst under held request", 32'(waits), 32'd0);
      fn_req = 1'b0;
      ctl_abort = 1'b1;
      @(negedge clk);
      ctl_abort = 1'b0;
      chk(st_running == 1'b0 && fn_ready, "R9", "idle abort immediate",
          32'({st_running, fn_ready}), 32'b01);

      // R7 looping pass
      ctl_loop = 1'b1;
      pulse_start();
      wait_done(seen);
      chk(seen && st_running && st_window == '0, "R7", "loop wrap",
          32'({seen, st_running, st_window}), 32'({1'b1, 1'b1, 4'd0}));
      @(negedge clk);
      chk(!st_done && !fn_ready, "R7", "pulse ends, next pass runs",
          32'({st_done, fn_ready}), 32'd0);
      stop_engine();
      ctl_loop = 1'b0;
      verify_image("contents after loop");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule